// File: doc/BRIEF.md
# CPU interrupt pin conditioner

This block sits between the external control pins of a processor core and the core's exception and clock-control logic. Each pin is brought into the core clock domain through a synchroniser. It is then compared against a register that holds the last sampled level of every pin. A pin is acted on only when its synchronised level differs from that stored level. Each pin has its own sensitivity. The external interrupt and system management interrupt pins are active-high levels. The machine check pin is edge sensitive and latches on a fall. The checkstop and hard reset pins are active low. The soft reset pin level is mirrored into a pending bit. The time base enable pin does not raise an interrupt; it gates a run enable for the time base counter.

The outputs are all registered:
- a four-bit pending vector;
- a single hard-interrupt request that is high while any pending bit is set;
- a halt request;
- a one-cycle core reset pulse;
- the time base run enable.

A small run-state machine has three states:
- `ST_RUN`: normal operation.
- `ST_HALT`: entered when checkstop is asserted.
- `ST_RESET`: a one-cycle state entered when hard reset is asserted.

It has four transitions:
- RUN to HALT on a checkstop assertion.
- RUN to RESET on a hard reset assertion.
- HALT to RESET on a hard reset assertion.
- RESET to RUN unconditionally.

Top module: `irq_pin_conditioner`

## Requirements
- R1: After reset, `pend_o`, `irq_req_o`, `halt_o`, `core_rst_o` and `tb_run_o` are 0, and `pin_state_o` equals the idle pattern `IDLE_LEVELS` (default 8'h1C: pins 2, 3 and 4 high).
- R2: The external interrupt pin (index 0) drives `pend_o[0]` and the system management pin (index 1) drives `pend_o[1]`. Each bit is set while its pin is high and cleared while it is low. A new pin level reaches the outputs on the third rising clock edge after it is applied.
- R3: A pin sample equal to the stored previous level produces no event. In particular, holding the machine check pin low after an acknowledge does not set `pend_o[2]` again.
- R4: A high-to-low transition on the machine check pin (index 2) sets `pend_o[2]`. A later rising edge does not clear it. Only `mchk_ack_i` clears it, and a new falling edge in the same cycle as the acknowledge wins.
- R5: A high-to-low transition on the checkstop pin (index 3) enters `ST_HALT` and raises `halt_o`. Releasing the pin does not leave the halt; only a hard reset does.
- R6: A high-to-low transition on the hard reset pin (index 4) enters `ST_RESET`. This produces a `core_rst_o` pulse exactly one cycle long and clears `halt_o`.
- R7: The soft reset pin (index 5) level is copied into `pend_o[3]`.
- R8: `irq_req_o` is high exactly when any bit of `pend_o` is set.
- R9: The time base enable pin (index 6) is active high. `tb_run_o` is 1 while it is high and 0 while it is low.
- R10: A pin index above 6 causes no change of `pend_o`, `halt_o`, `core_rst_o` or `tb_run_o`, but its level is recorded in `pin_state_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Raw external control pins, asynchronous |
| mchk_ack_i | input | 1 | Acknowledge that clears the machine-check pending bit |
| pend_o | output | 4 | Pending bits: 0 external, 1 system management, 2 machine check, 3 soft reset |
| irq_req_o | output | 1 | Hard-interrupt request, high while any pending bit is set |
| halt_o | output | 1 | Halt request from checkstop |
| core_rst_o | output | 1 | One-cycle core reset request |
| tb_run_o | output | 1 | Time base run enable |
| pin_state_o | output | NPINS | Previous-level register contents |

## Verification
The bench builds the block with its default parameters: eight pins, two synchroniser stages and the idle pattern 8'h1C. With eight pins, index 7 exists as a spare pin that no behaviour is tied to, so the ignored-pin case can be driven and observed through `pin_state_o`. With two stages, every pin change lands on a fixed third edge, so each check samples at a known cycle. The idle pattern starts the active-low and falling-edge pins high, which lets their first assertion appear as a real transition.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned PIN_EXT   = 0;
    localparam int unsigned PIN_SMI   = 1;
    localparam int unsigned PIN_MCHK  = 2;
    localparam int unsigned PIN_CSTOP = 3;
    localparam int unsigned PIN_HRST  = 4;
    localparam int unsigned PIN_SRST  = 5;
    localparam int unsigned PIN_TBEN  = 6;
    localparam int unsigned PIN_KNOWN = 7;

    localparam int unsigned PEND_W    = 4;
    localparam int unsigned PB_EXT    = 0;
    localparam int unsigned PB_SMI    = 1;
    localparam int unsigned PB_MCHK   = 2;
    localparam int unsigned PB_SRST   = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_RESET = 2'd2
    } core_st_e;
endpackage

// File: rtl/irqc_pin_sync.sv
module irqc_pin_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= IDLE;
        else        chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= IDLE;
            else        chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/irqc_pin_track.sv
module irqc_pin_track #(
    parameter int unsigned W     = 8,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] samp,
    output logic [W-1:0] chg,
    output logic [W-1:0] prev
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= samp;
    end

    assign chg  = samp ^ prev_q;
    assign prev = prev_q;
endmodule

// File: rtl/irqc_run_fsm.sv
module irqc_run_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic hrst_req,
    output logic halt,
    output logic rst_pulse
);
    core_st_e st_q, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (hrst_req)      st_n = ST_RESET;
                else if (stop_req) st_n = ST_HALT;
            end
            ST_HALT: begin
                if (hrst_req)      st_n = ST_RESET;
            end
            ST_RESET: begin
                st_n = ST_RUN;
            end
            default: st_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt      <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            halt      <= (st_n == ST_HALT);
            rst_pulse <= (st_n == ST_RESET);
        end
    end
endmodule

// File: rtl/irq_pin_conditioner.sv
module irq_pin_conditioner
    import irqc_pkg::*;
#(
    parameter int unsigned NPINS           = 8,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter logic [NPINS-1:0] IDLE_LEVELS = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_i,
    input  logic              mchk_ack_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              irq_req_o,
    output logic              halt_o,
    output logic              core_rst_o,
    output logic              tb_run_o,
    output logic [NPINS-1:0]  pin_state_o
);
    localparam int unsigned NP = (NPINS < PIN_KNOWN) ? PIN_KNOWN : NPINS;

    logic [NPINS-1:0]  samp, chg;
    logic [PEND_W-1:0] pend_q, pend_n;
    logic              irq_q, tb_q, tb_n;
    logic              stop_req, hrst_req;

    irqc_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .IDLE(IDLE_LEVELS)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins_i), .dout(samp)
    );

    irqc_pin_track #(.W(NPINS), .IDLE(IDLE_LEVELS)) u_track (
        .clk(clk), .rst_n(rst_n), .samp(samp), .chg(chg), .prev(pin_state_o)
    );

    assign stop_req = chg[PIN_CSTOP] & ~samp[PIN_CSTOP];
    assign hrst_req = chg[PIN_HRST]  & ~samp[PIN_HRST];

    irqc_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .hrst_req(hrst_req),
        .halt(halt_o), .rst_pulse(core_rst_o)
    );

    always_comb begin
        pend_n = pend_q;
        tb_n   = tb_q;
        if (chg[PIN_EXT])  pend_n[PB_EXT]  = samp[PIN_EXT];
        if (chg[PIN_SMI])  pend_n[PB_SMI]  = samp[PIN_SMI];
        if (chg[PIN_SRST]) pend_n[PB_SRST] = samp[PIN_SRST];
        if (mchk_ack_i)    pend_n[PB_MCHK] = 1'b0;
        if (chg[PIN_MCHK] && !samp[PIN_MCHK]) pend_n[PB_MCHK] = 1'b1;
        if (chg[PIN_TBEN]) tb_n = samp[PIN_TBEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
            tb_q   <= 1'b0;
        end else begin
            pend_q <= pend_n;
            irq_q  <= |pend_n;
            tb_q   <= tb_n;
        end
    end

    assign pend_o    = pend_q;
    assign irq_req_o = irq_q;
    assign tb_run_o  = tb_q;

    if (NP != NPINS) begin : g_bad_width
        initial $display("irq_pin_conditioner: NPINS must be at least %0d", PIN_KNOWN);
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mchk_ack_i,
    input logic [3:0]       pend_o,
    input logic             irq_req_o,
    input logic             halt_o,
    input logic             core_rst_o
);
    a_r8_irq_matches_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o == (|pend_o));

    a_r4_mchk_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[2] && !mchk_ack_i) |=> pend_o[2]);

    a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> (halt_o || core_rst_o));

    a_r6_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o);

    a_r6_rst_ends_halt: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> !halt_o);
endmodule

bind irq_pin_conditioner irqc_checker #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .mchk_ack_i(mchk_ack_i), .pend_o(pend_o),
    .irq_req_o(irq_req_o), .halt_o(halt_o), .core_rst_o(core_rst_o)
);

// File: tb/tb_irq_pin_conditioner.sv
module tb_irq_pin_conditioner;
    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPINS-1:0] pins_i = 8'h1C;
    logic             mchk_ack_i = 1'b0;
    logic [3:0]       pend_o;
    logic             irq_req_o, halt_o, core_rst_o, tb_run_o;
    logic [NPINS-1:0] pin_state_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_conditioner dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .mchk_ack_i(mchk_ack_i),
        .pend_o(pend_o), .irq_req_o(irq_req_o), .halt_o(halt_o),
        .core_rst_o(core_rst_o), .tb_run_o(tb_run_o), .pin_state_o(pin_state_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive a pin at the falling edge, then wait until the third rising edge has passed
    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pins_i[idx] = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 pend", pend_o, 0);
        check("R1 irq", irq_req_o, 0);
        check("R1 halt", halt_o, 0);
        check("R1 rst", core_rst_o, 0);
        check("R1 tb", tb_run_o, 0);
        check("R1 state", pin_state_o, 8'h1C);
    endtask

    task automatic t_levels();
        @(negedge clk);
        pins_i[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 latency not yet", pend_o[0], 0);
        @(posedge clk); @(negedge clk);
        check("R2 ext set", pend_o[0], 1);
        check("R8 irq ext", irq_req_o, 1);
        set_pin(1, 1'b1);
        check("R2 smi set", pend_o, 4'b0011);
        set_pin(0, 1'b1);
        check("R3 same level no change", pend_o, 4'b0011);
        set_pin(0, 1'b0);
        check("R2 ext clr", pend_o, 4'b0010);
        set_pin(1, 1'b0);
        check("R2 smi clr", pend_o, 0);
        check("R8 irq drop", irq_req_o, 0);
    endtask

    task automatic t_mchk();
        set_pin(2, 1'b0);
        check("R4 mchk set", pend_o[2], 1);
        check("R8 irq mchk", irq_req_o, 1);
        set_pin(2, 1'b1);
        check("R4 rise keeps", pend_o[2], 1);
        set_pin(2, 1'b0);
        mchk_ack_i = 1'b1;
        @(posedge clk); @(negedge clk);
        mchk_ack_i = 1'b0;
        check("R4 ack clears", pend_o[2], 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R3 held low no reset", pend_o[2], 0);
        check("R8 irq off", irq_req_o, 0);
        set_pin(2, 1'b1);
    endtask

    task automatic t_halt_reset();
        set_pin(3, 1'b0);
        check("R5 halt", halt_o, 1);
        set_pin(3, 1'b1);
        check("R5 release keeps halt", halt_o, 1);
        @(negedge clk);
        pins_i[4] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 pulse", core_rst_o, 1);
        check("R6 halt cleared", halt_o, 0);
        @(posedge clk); @(negedge clk);
        check("R6 pulse one cycle", core_rst_o, 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R6 held low no repeat", core_rst_o, 0);
        set_pin(4, 1'b1);
        check("R6 release no pulse", core_rst_o, 0);
    endtask

    task automatic t_srst_tb();
        set_pin(5, 1'b1);
        check("R7 srst set", pend_o, 4'b1000);
        check("R8 irq srst", irq_req_o, 1);
        set_pin(5, 1'b0);
        check("R7 srst clr", pend_o[3], 0);
        set_pin(6, 1'b1);
        check("R9 tb run", tb_run_o, 1);
        set_pin(6, 1'b0);
        check("R9 tb frozen", tb_run_o, 0);
    endtask

    task automatic t_unknown();
        set_pin(7, 1'b1);
        check("R10 recorded", pin_state_o[7], 1);
        check("R10 pend", pend_o, 0);
        check("R10 halt", halt_o, 0);
        check("R10 rst", core_rst_o, 0);
        check("R10 tb", tb_run_o, 0);
        set_pin(7, 1'b0);
        check("R10 recorded low", pin_state_o[7], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();
        t_mchk();
        t_halt_reset();
        t_srst_tb();
        t_unknown();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule